// File: doc/BRIEF.md
# L1.2 Exit Power-On Delay Timer

This block keeps a link port from driving its interface too early when it leaves the L1.2 low-power substate. The block starts timing when two conditions hold together: the L1.2 exit request is active, and the active-low clock-request pin has been seen asserted after synchronization. It then counts a power-on wait and a common-mode restore wait, both in microsecond ticks. Only after both waits end does it raise drive-enable, together with a one-cycle done pulse. When no exit is in progress, drive-enable stays high, which is normal operation.

The wait lengths come from a 32-bit capability word. A 2-bit scale code picks a unit of 2, 10 or 100 µs, and a 5-bit multiplier gives the number of units. An 8-bit field gives the restore time in µs. Five support flags are also held in the word. The capability word is loaded through a valid/ready write stream and can always be read back on a parallel output.

The write stream has simple back-pressure rules. The ready signal is high only while the timer is idle. A write is taken on a clock edge where valid and ready are both high. The source must hold the write data stable until the write is taken. No write can therefore change the timing in the middle of a wait.

Top module: `l12_exit_timer`

## Requirements
- R1: After reset, `cap_word` reads 32'h0068FF1F. This means value field 0xd, scale 00, restore time 0xff and all five flags set. `cfg_err` is 0, and `drive_en` and `cfg_ready` are 1.
- R2: `cfg_ready` is high exactly when the timer is idle. A write is taken when `cfg_valid` and `cfg_ready` are both high at a clock edge, and it stores these fields: flags at bits 4:0, restore time at bits 15:8, scale at bits 17:16 and multiplier at bits 23:19. Bits 7:5, bit 18 and bits 31:24 always read 0. `cap_word` does not change unless a write is taken.
- R3: The scale codes map to units as follows: 00 is 2, 01 is 10, 10 is 100 and 11 is 100. The power-on wait is multiplier × unit ticks of `us_tick`.
- R4: The timer starts only when all three conditions hold: `exit_req` is high, the L1.2 gate is open, and `clkreq_n` has been low at two successive clock edges. The L1.2 gate is flag bit 4 AND (bit 0 OR bit 2).
- R5: While `exit_req` is high and the gate is open, `drive_en` stays low until the waits complete. `drive_en` is high at every other time.
- R6: The restore countdown of bits 15:8 ticks runs after the power-on wait. After it ends, `drive_en` rises and `wait_done` pulses high for exactly one cycle. With `us_tick` high on every cycle, `wait_done` appears N+C+5 clock edges after `clkreq_n` falls, where N is the power-on tick count and C is the restore tick count.
- R7: During either countdown, the timer returns to idle if the synchronized clock request deasserts or if `exit_req` drops. The next assertion restarts the full wait.
- R8: `cfg_err` is set by a write that is taken with scale code 11 or with any reserved bit set. It stays set until reset.
- R9: With the L1.2 gate closed, an exit request with clock request asserted never starts the timer: `drive_en` stays high and `cfg_ready` stays high.
- R10: A multiplier of 0 and a restore time of 0 give the shortest wait, which is 5 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| clkreq_n | input | 1 | Active-low clock-request pin, asynchronous |
| exit_req | input | 1 | L1.2 exit in progress |
| cfg_valid | input | 1 | Capability write valid |
| cfg_ready | output | 1 | Capability write accepted this edge if valid |
| cfg_data | input | 32 | Capability write word |
| cap_word | output | 32 | Capability word read-back |
| drive_en | output | 1 | Interface may be driven |
| wait_done | output | 1 | One-cycle pulse when the exit waits complete |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench builds the block with its default parameters: a 5-bit multiplier, units of 2, 10 and 100, an 8-bit restore field and a two-stage synchronizer. These defaults put the longest wait of 3100 plus 255 ticks within a short run when `us_tick` is high on every cycle. A sparse tick pattern makes the countdown hold its value between ticks. Together they cover every scale code, including the reserved code, the zero-length wait, aborts in the middle of a wait and writes stalled by back-pressure.

// File: rtl/l12x_pkg.sv
package l12x_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PWR  = 2'd1,
    ST_CM   = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam int CAP_W = 32;
  localparam int SCALE_W = 2;
  localparam int FLAG_W = 5;
endpackage

// File: rtl/l12x_sync.sv
module l12x_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/l12x_cap_reg.sv
module l12x_cap_reg
  import l12x_pkg::*;
#(
  parameter int                 VAL_W     = 5,
  parameter int                 CM_W      = 8,
  parameter logic [VAL_W-1:0]   RST_VAL   = 5'hd,
  parameter logic [CM_W-1:0]    RST_CM    = 8'hff,
  parameter logic [SCALE_W-1:0] RST_SCALE = 2'b00,
  parameter logic [FLAG_W-1:0]  RST_FLAGS = 5'h1f
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic               wr_ready,
  input  logic [CAP_W-1:0]   wr_data,
  output logic [CAP_W-1:0]   cap_word,
  output logic               l12_ok,
  output logic [SCALE_W-1:0] scale,
  output logic [VAL_W-1:0]   pwr_val,
  output logic [CM_W-1:0]    cm_time,
  output logic               cfg_err
);
  localparam int FLAG_LO  = 0;
  localparam int CM_LO    = 8;
  localparam int SCALE_LO = 16;
  localparam int VAL_LO   = 19;

  logic [FLAG_W-1:0] flags;
  logic              take;
  logic              bad_cfg;

  assign take    = wr_valid & wr_ready;
  assign bad_cfg = (wr_data[SCALE_LO +: SCALE_W] == 2'b11) |
                   (|wr_data[7:5]) | wr_data[18] | (|wr_data[31:24]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= RST_FLAGS;
      cm_time <= RST_CM;
      scale   <= RST_SCALE;
      pwr_val <= RST_VAL;
      cfg_err <= 1'b0;
    end else if (take) begin
      flags   <= wr_data[FLAG_LO +: FLAG_W];
      cm_time <= wr_data[CM_LO +: CM_W];
      scale   <= wr_data[SCALE_LO +: SCALE_W];
      pwr_val <= wr_data[VAL_LO +: VAL_W];
      if (bad_cfg) cfg_err <= 1'b1;
    end
  end

  assign cap_word = {8'h00, pwr_val, 1'b0, scale, cm_time, 3'b000, flags};
  assign l12_ok   = flags[4] & (flags[0] | flags[2]);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(cap_word));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/l12x_seq.sv
module l12x_seq
  import l12x_pkg::*;
#(
  parameter int VAL_W = 5,
  parameter int CM_W  = 8,
  parameter int U0    = 2,
  parameter int U1    = 10,
  parameter int U2    = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick,
  input  logic               creq,
  input  logic               exit_req,
  input  logic               l12_ok,
  input  logic [SCALE_W-1:0] scale,
  input  logic [VAL_W-1:0]   pwr_val,
  input  logic [CM_W-1:0]    cm_time,
  output logic               idle,
  output logic               drive_en,
  output logic               wait_done
);
  localparam int MAX_PWR = ((1 << VAL_W) - 1) * U2;
  localparam int PWR_CW  = $clog2(MAX_PWR + 1);
  localparam int CNT_W   = (PWR_CW > CM_W) ? PWR_CW : CM_W;

  seq_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] unit_c;
  logic [CNT_W-1:0] pwr_load;
  logic             act, keep, done_n;

  always_comb begin
    case (scale)
      2'b00:   unit_c = CNT_W'(U0);
      2'b01:   unit_c = CNT_W'(U1);
      default: unit_c = CNT_W'(U2);
    endcase
  end

  assign pwr_load = CNT_W'(pwr_val) * unit_c;
  assign act      = exit_req & l12_ok;
  assign keep     = act & creq;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    done_n  = 1'b0;
    case (state)
      ST_IDLE: if (keep) begin
        state_n = ST_PWR;
        cnt_n   = pwr_load;
      end
      ST_PWR: begin
        if (!keep) state_n = ST_IDLE;
        else if (cnt == '0) begin
          state_n = ST_CM;
          cnt_n   = CNT_W'(cm_time);
        end else if (us_tick) cnt_n = cnt - 1'b1;
      end
      ST_CM: begin
        if (!keep) state_n = ST_IDLE;
        else if (cnt == '0) begin
          state_n = ST_DONE;
          done_n  = 1'b1;
        end else if (us_tick) cnt_n = cnt - 1'b1;
      end
      default: if (!act) state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wait_done <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      wait_done <= done_n;
    end
  end

  assign idle     = (state == ST_IDLE);
  assign drive_en = (state == ST_DONE) | ~act;

  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PWR || state == ST_CM) && keep && us_tick && cnt != '0)
      |=> cnt == CNT_W'($past(cnt) - 1'b1));
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !keep) |=> state == ST_IDLE);
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PWR || state == ST_CM) && !creq) |=> state == ST_IDLE);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |=> !wait_done);
endmodule

// File: rtl/l12_exit_timer.sv
module l12_exit_timer
  import l12x_pkg::*;
#(
  parameter int VAL_W     = 5,
  parameter int CM_W      = 8,
  parameter int SYNC_STG  = 2,
  parameter int UNIT_LO   = 2,
  parameter int UNIT_MID  = 10,
  parameter int UNIT_HI   = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        clkreq_n,
  input  logic        exit_req,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  input  logic [31:0] cfg_data,
  output logic [31:0] cap_word,
  output logic        drive_en,
  output logic        wait_done,
  output logic        cfg_err
);
  logic               creq_n_s;
  logic               l12_ok;
  logic [SCALE_W-1:0] scale;
  logic [VAL_W-1:0]   pwr_val;
  logic [CM_W-1:0]    cm_time;
  logic               idle;

  l12x_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(clkreq_n), .q(creq_n_s)
  );

  l12x_cap_reg #(.VAL_W(VAL_W), .CM_W(CM_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_valid(cfg_valid), .wr_ready(cfg_ready),
    .wr_data(cfg_data), .cap_word(cap_word), .l12_ok(l12_ok), .scale(scale),
    .pwr_val(pwr_val), .cm_time(cm_time), .cfg_err(cfg_err)
  );

  l12x_seq #(.VAL_W(VAL_W), .CM_W(CM_W), .U0(UNIT_LO), .U1(UNIT_MID), .U2(UNIT_HI)) u_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .creq(~creq_n_s),
    .exit_req(exit_req), .l12_ok(l12_ok), .scale(scale), .pwr_val(pwr_val),
    .cm_time(cm_time), .idle(idle), .drive_en(drive_en), .wait_done(wait_done)
  );

  assign cfg_ready = idle;

  p_done_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> drive_en);
  p_busy_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> $stable(cap_word));
endmodule

// File: tb/l12_exit_timer_tb.sv
module l12_exit_timer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        clkreq_n = 1'b1;
  logic        exit_req = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        cfg_ready;
  logic [31:0] cap_word;
  logic        drive_en, wait_done, cfg_err;

  int checks = 0;
  int fails = 0;
  bit tb_over = 0;
  int tick_mode = 0; // 0: every cycle, 1: every third cycle
  int tick_ctr = 0;

  always #(CLK_P/2) clk = ~clk;

  l12_exit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .clkreq_n(clkreq_n),
    .exit_req(exit_req), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .cap_word(cap_word), .drive_en(drive_en),
    .wait_done(wait_done), .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_s1 = 1, m_s2 = 1;
  int m_state = 0, m_cnt = 0;
  bit m_done = 0;
  int m_flags = 31, m_cm = 255, m_scale = 0, m_val = 13;
  bit m_err = 0;

  function automatic int unit_of(int s);
    return (s == 0) ? 2 : (s == 1) ? 10 : 100;
  endfunction

  function automatic bit m_gate();
    return ((m_flags >> 4) & 1) && (((m_flags & 1) != 0) || ((m_flags & 4) != 0));
  endfunction

  function automatic logic [31:0] m_word();
    return (32'(m_val) << 19) | (32'(m_scale) << 16) | (32'(m_cm) << 8) | 32'(m_flags);
  endfunction

  always @(posedge clk) begin
    int ns, nc;
    bit nd, act, cr;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_state = 0; m_cnt = 0; m_done = 0;
      m_flags = 31; m_cm = 255; m_scale = 0; m_val = 13; m_err = 0;
    end else begin
      ns = m_state; nc = m_cnt; nd = 0;
      act = exit_req && m_gate();
      cr = !m_s2;
      if (m_state == 0) begin
        if (act && cr) begin ns = 1; nc = m_val * unit_of(m_scale); end
      end else if (m_state == 1 || m_state == 2) begin
        if (!(act && cr)) ns = 0;
        else if (m_cnt == 0) begin
          if (m_state == 1) begin ns = 2; nc = m_cm; end
          else begin ns = 3; nd = 1; end
        end else if (us_tick) nc = m_cnt - 1;
      end else if (!act) ns = 0;
      if (cfg_valid && m_state == 0) begin
        m_flags = int'(cfg_data[4:0]); m_cm = int'(cfg_data[15:8]);
        m_scale = int'(cfg_data[17:16]); m_val = int'(cfg_data[23:19]);
        if (cfg_data[17:16] == 2'b11 || cfg_data[7:5] != 0 || cfg_data[18] || cfg_data[31:24] != 0)
          m_err = 1;
      end
      m_s2 = m_s1; m_s1 = clkreq_n;
      m_state = ns; m_cnt = nc; m_done = nd;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !tb_over) begin
      chk("R5 drive_en", 32'(drive_en), 32'((m_state == 3) || !(exit_req && m_gate())));
      chk("R6 wait_done", 32'(wait_done), 32'(m_done));
      chk("R2 cfg_ready", 32'(cfg_ready), 32'(m_state == 0));
      chk("R2 cap_word", cap_word, m_word());
      chk("R8 cfg_err", 32'(cfg_err), 32'(m_err));
    end
  end

  // Tick source
  always @(posedge clk) begin
    #1;
    tick_ctr = (tick_ctr + 1) % 3;
    us_tick = (tick_mode == 0) ? 1'b1 : (tick_ctr == 0);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(logic [31:0] d);
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_data = d;
    forever begin
      @(negedge clk);
      if (cfg_ready) break;
    end
    @(posedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic run_wait(output int n);
    @(posedge clk); #1;
    exit_req = 1'b1; clkreq_n = 1'b0;
    n = 0;
    for (int i = 0; i < 8000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (wait_done) break;
    end
  endtask

  task automatic end_exit();
    @(posedge clk); #1;
    exit_req = 1'b0; clkreq_n = 1'b1;
    step(4);
  endtask

  function automatic logic [31:0] mk(int flags, int cm, int sc, int v);
    return (32'(v) << 19) | (32'(sc) << 16) | (32'(cm) << 8) | 32'(flags);
  endfunction

  initial begin
    int n;
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cap_word", cap_word, 32'h0068FF1F);
    chk("R1 reset cfg_err", 32'(cfg_err), 0);
    chk("R1 reset drive_en", 32'(drive_en), 1);
    chk("R1 reset cfg_ready", 32'(cfg_ready), 1);

    // Default wait: 13*2 + 255
    run_wait(n);
    chk("R3 R6 default wait length", 32'(n), 32'(26 + 255 + 5));
    chk("R6 drive_en after done", 32'(drive_en), 1);
    end_exit();

    // Scale 01
    cfg_write(mk(31, 4, 1, 3));
    @(negedge clk);
    chk("R2 readback", cap_word, mk(31, 4, 1, 3));
    run_wait(n);
    chk("R3 scale01 wait", 32'(n), 32'(30 + 4 + 5));
    end_exit();

    // Scale 10, no restore time
    cfg_write(mk(31, 0, 2, 2));
    run_wait(n);
    chk("R3 scale10 wait", 32'(n), 32'(200 + 0 + 5));
    end_exit();

    // Reserved scale plus reserved bits set
    cfg_write(mk(31, 3, 3, 1) | 32'hFF0400E0);
    @(negedge clk);
    chk("R2 reserved bits read zero", cap_word, mk(31, 3, 3, 1));
    chk("R8 cfg_err set", 32'(cfg_err), 1);
    run_wait(n);
    chk("R3 reserved scale acts as 100", 32'(n), 32'(100 + 3 + 5));
    end_exit();

    // Zero wait
    cfg_write(mk(31, 0, 0, 0));
    @(negedge clk);
    chk("R8 cfg_err stays set", 32'(cfg_err), 1);
    run_wait(n);
    chk("R10 minimum wait", 32'(n), 32'(5));
    end_exit();

    // Abort by clock request deassertion, then full restart
    cfg_write(mk(31, 2, 1, 2));
    @(posedge clk); #1;
    exit_req = 1'b1; clkreq_n = 1'b0;
    step(10);
    clkreq_n = 1'b1;
    step(4);
    @(negedge clk);
    chk("R7 back to idle after abort", 32'(cfg_ready), 1);
    chk("R7 drive held off", 32'(drive_en), 0);
    clkreq_n = 1'b1;
    exit_req = 1'b0;
    step(1);
    run_wait(n);
    chk("R7 full restart length", 32'(n), 32'(20 + 2 + 5));
    end_exit();

    // Abort by exit_req drop, write stalled while busy
    @(posedge clk); #1;
    exit_req = 1'b1; clkreq_n = 1'b0;
    step(6);
    cfg_valid = 1'b1; cfg_data = mk(31, 9, 0, 9);
    step(3);
    @(negedge clk);
    chk("R2 stalled while busy", 32'(cfg_ready), 0);
    chk("R2 word unchanged while busy", cap_word, mk(31, 2, 1, 2));
    @(posedge clk); #1;
    exit_req = 1'b0;
    step(2);
    cfg_valid = 1'b0;
    @(negedge clk);
    chk("R7 exit drop returns idle", 32'(cfg_ready), 1);
    chk("R2 stalled write taken", cap_word, mk(31, 9, 0, 9));
    end_exit();

    // Sparse ticks
    tick_mode = 1;
    run_wait(n);
    chk("R3 sparse tick done seen", 32'(wait_done), 1);
    end_exit();
    tick_mode = 0;

    // Gate closed: bit 4 clear
    cfg_write(mk(15, 1, 0, 1));
    @(posedge clk); #1;
    exit_req = 1'b1; clkreq_n = 1'b0;
    step(20);
    @(negedge clk);
    chk("R9 gate closed drive_en", 32'(drive_en), 1);
    chk("R9 gate closed idle", 32'(cfg_ready), 1);
    chk("R4 no start without gate", 32'(wait_done), 0);
    end_exit();

    // Gate via bit 2 only
    cfg_write(mk(16 | 4, 1, 0, 1));
    run_wait(n);
    chk("R4 gate via bit 2", 32'(n), 32'(2 + 1 + 5));
    end_exit();

    tb_over = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    tb_over = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule